// File: doc/BRIEF.md
# Radix Page Table Walker

This block turns a virtual address into a leaf page-table entry by reading one entry per level of a radix page table held in memory. A walk begins with a `start` pulse, which carries the virtual address, the physical base of the top-level table and a flag that says whether the requested access includes a write. The walker issues one memory read at a time and follows pointer entries downward. At a leaf it sets the referenced bit, and sets the dirty bit as well for write requests, then stores the entry back. For a leaf found above the bottom level it merges the untranslated page-number bits into the returned entry. It ends the walk with a one-cycle `done` pulse, the `fail` flag and the resulting entry.

Every physical address the walker forms is compared against a fixed memory size, and so is the page address of the final entry. Storage of translations, permission checks on the result and raising faults are left to the surrounding logic. The depth, the index width per level, the page size and the memory size are parameters. The defaults are three levels, ten index bits per level, 4 KiB pages and 16 MiB of memory, with 64-bit entries.

Entry bit layout: bit 0 valid, bit 1 table (points to the next level), bits 2..7 access permissions (not interpreted), bit 8 referenced, bit 9 dirty, bits 63:12 page number. With the defaults the virtual address is 42 bits wide. The top-level index is va[41:32], the middle index va[31:22] and the bottom index va[21:12].

Top module: `ptw_walker`

## Requirements
- R1: A virtual address whose bits 63 down to 41 are not all equal (not a sign extension of bit 41) fails with no memory read. An address whose bits are all ones there is walked normally.
- R2: The first read goes to root + va[41:32]*8. Each further read goes to the current base + the next lower index field * 8, in order from the top level to the bottom level.
- R3: If an entry address is at or beyond the memory size (16 MiB), the walk fails without issuing that read.
- R4: An entry whose valid bit (bit 0) is clear ends the walk with fail set and a leaf of zero, and nothing is written.
- R5: A valid entry with the table bit (bit 1) set gives the next base as its bits 63:12 with the low 12 bits cleared.
- R6: At a leaf (valid, table bit clear), the entry is written back to the address it was read from with bit 8 set. Bit 9 is also set when the request includes a write. Exactly one write occurs per leaf.
- R7: A leaf found at level k (top = 0) returns the read entry ORed with the referenced/dirty update and with the low (2-k)*10 virtual page-number bits placed at bit 12 upward.
- R8: If the returned leaf's page address (bits 63:12) is at or beyond the memory size, the walk fails with a zero leaf. The write-back has still happened.
- R9: A table-bit entry at the bottom level fails the walk with a zero leaf and no write.
- R10: `done` is high for exactly one cycle per walk. At most one read is outstanding, and every failed walk reports `leafPte` = 0.
- R11: After reset, `done`, `memRdReq` and `memWrReq` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low reset |
| start | input | 1 | Begin a walk (accepted while idle) |
| vaddr | input | 64 | Virtual address to translate |
| rootBase | input | 64 | Physical base of the top-level table |
| reqWrite | input | 1 | Requested access includes a write |
| memRdReq | output | 1 | Read request strobe |
| memRdAddr | output | 64 | Read address of the entry |
| memRdValid | input | 1 | Read data valid |
| memRdData | input | 64 | Entry returned by memory |
| memWrReq | output | 1 | Write-back strobe |
| memWrAddr | output | 64 | Write-back address |
| memWrData | output | 64 | Updated entry |
| done | output | 1 | Walk finished (one cycle) |
| fail | output | 1 | Walk failed |
| leafPte | output | 64 | Resulting leaf entry, zero on failure |

## Verification
A corrupted level counter or base register shows up at the ports on the very next read request: the read address leaves the expected sequence or crosses the memory bound, before any result exists. Errors in the leaf merge or in the update bits appear in the single write-back and in the value that `done` reports, a few cycles later. A stuck control state shows up either as a second read while one is pending, or as `done` lasting more than one cycle.

// File: rtl/ptw_pkg.sv
package ptw_pkg;
  localparam int PTE_W      = 64;
  localparam int PTE_SHIFT  = 3;
  localparam int BIT_VALID  = 0;
  localparam int BIT_TABLE  = 1;
  localparam int BIT_REF    = 8;
  localparam int BIT_DIRTY  = 9;

  typedef struct packed {
    logic capture;
    logic latchPte;
    logic descend;
    logic takeLeaf;
    logic markFail;
  } ptwStrobe_t;

  typedef struct packed {
    logic signBad;
    logic addrOob;
    logic pteValid;
    logic pteTable;
    logic lastLevel;
    logic physOob;
  } ptwFlags_t;

  typedef enum logic [2:0] {
    ST_IDLE, ST_CHECK, ST_ISSUE, ST_WAIT, ST_EVAL, ST_WRBACK, ST_PCHK, ST_FINISH
  } ptwState_t;
endpackage

// File: rtl/ptw_ctrl.sv
module ptw_ctrl
  import ptw_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       start,
  input  logic       memRdValid,
  input  ptwFlags_t  flags,
  output ptwStrobe_t stb,
  output logic       memRdReq,
  output logic       memWrReq,
  output logic       done
);
  ptwState_t stateQ, stateD;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) stateQ <= ST_IDLE;
    else       stateQ <= stateD;
  end

  always_comb begin
    stateD   = stateQ;
    stb      = '0;
    memRdReq = 1'b0;
    memWrReq = 1'b0;
    done     = 1'b0;
    unique case (stateQ)
      ST_IDLE: begin
        if (start) begin
          stb.capture = 1'b1;
          stateD      = ST_CHECK;
        end
      end
      ST_CHECK: begin
        if (flags.signBad || flags.addrOob) begin
          stb.markFail = 1'b1;
          stateD       = ST_FINISH;
        end else begin
          stateD = ST_ISSUE;
        end
      end
      ST_ISSUE: begin
        memRdReq = 1'b1;
        stateD   = ST_WAIT;
      end
      ST_WAIT: begin
        if (memRdValid) begin
          stb.latchPte = 1'b1;
          stateD       = ST_EVAL;
        end
      end
      ST_EVAL: begin
        if (!flags.pteValid) begin
          stb.markFail = 1'b1;
          stateD       = ST_FINISH;
        end else if (flags.pteTable) begin
          if (flags.lastLevel) begin
            stb.markFail = 1'b1;
            stateD       = ST_FINISH;
          end else begin
            stb.descend = 1'b1;
            stateD      = ST_CHECK;
          end
        end else begin
          stateD = ST_WRBACK;
        end
      end
      ST_WRBACK: begin
        memWrReq     = 1'b1;
        stb.takeLeaf = 1'b1;
        stateD       = ST_PCHK;
      end
      ST_PCHK: begin
        if (flags.physOob) stb.markFail = 1'b1;
        stateD = ST_FINISH;
      end
      ST_FINISH: begin
        done   = 1'b1;
        stateD = ST_IDLE;
      end
      default: stateD = ST_IDLE;
    endcase
  end
endmodule

// File: rtl/ptw_datapath.sv
module ptw_datapath
  import ptw_pkg::*;
#(
  parameter int          LEVELS    = 3,
  parameter int          IDX_BITS  = 10,
  parameter int          PG_SHIFT  = 12,
  parameter logic [63:0] MEM_BYTES = 64'h0100_0000
) (
  input  logic        clk,
  input  logic        rstN,
  input  ptwStrobe_t  stb,
  input  logic [63:0] vaddr,
  input  logic [63:0] rootBase,
  input  logic        reqWrite,
  input  logic [63:0] memRdData,
  output ptwFlags_t   flags,
  output logic [63:0] pteAddr,
  output logic [63:0] wrData,
  output logic        failQ,
  output logic [63:0] resultQ
);
  localparam int VA_BITS = PG_SHIFT + LEVELS * IDX_BITS;
  localparam int LVL_W   = (LEVELS > 1) ? $clog2(LEVELS) : 1;

  logic [63:0]      vaQ, baseQ, pteQ;
  logic             wrQ;
  logic [LVL_W-1:0] levelQ;

  logic [IDX_BITS-1:0] idxLvl  [LEVELS];
  logic [63:0]         fillLvl [LEVELS];
  logic [IDX_BITS-1:0] idxCur;
  logic [63:0]         fillCur;
  logic [63:0]         updPte;
  logic [63:0]         leafPte;
  logic [63:0]         nextBase;
  logic [63-VA_BITS+1:0] upperBits;

  // Per-level index field and superpage fill bits
  for (genvar g = 0; g < LEVELS; g++) begin : g_lvl
    localparam int REM = (LEVELS - 1 - g) * IDX_BITS;
    assign idxLvl[g]  = vaQ[PG_SHIFT + REM +: IDX_BITS];
    assign fillLvl[g] = ((vaQ >> PG_SHIFT) & ((64'd1 << REM) - 64'd1)) << PG_SHIFT;
  end

  always_comb begin
    idxCur  = '0;
    fillCur = '0;
    for (int i = 0; i < LEVELS; i++) begin
      if (levelQ == LVL_W'(i)) begin
        idxCur  = idxLvl[i];
        fillCur = fillLvl[i];
      end
    end
  end

  assign pteAddr   = baseQ + (64'(idxCur) << PTE_SHIFT);
  assign upperBits = vaQ[63:VA_BITS-1];
  assign nextBase  = {pteQ[63:PG_SHIFT], {PG_SHIFT{1'b0}}};

  always_comb begin
    updPte = pteQ;
    updPte[BIT_REF] = 1'b1;
    if (wrQ) updPte[BIT_DIRTY] = 1'b1;
  end

  assign leafPte = updPte | fillCur;
  assign wrData  = updPte;

  assign flags.signBad   = !((&upperBits) || !(|upperBits));
  assign flags.addrOob   = pteAddr >= MEM_BYTES;
  assign flags.pteValid  = pteQ[BIT_VALID];
  assign flags.pteTable  = pteQ[BIT_TABLE];
  assign flags.lastLevel = levelQ == LVL_W'(LEVELS - 1);
  assign flags.physOob   = {resultQ[63:PG_SHIFT], {PG_SHIFT{1'b0}}} >= MEM_BYTES;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      vaQ     <= '0;
      baseQ   <= '0;
      pteQ    <= '0;
      wrQ     <= 1'b0;
      levelQ  <= '0;
      failQ   <= 1'b0;
      resultQ <= '0;
    end else begin
      if (stb.capture) begin
        vaQ     <= vaddr;
        baseQ   <= rootBase;
        wrQ     <= reqWrite;
        levelQ  <= '0;
        failQ   <= 1'b0;
        resultQ <= '0;
      end
      if (stb.latchPte) pteQ <= memRdData;
      if (stb.descend) begin
        baseQ  <= nextBase;
        levelQ <= levelQ + LVL_W'(1);
      end
      if (stb.takeLeaf) resultQ <= leafPte;
      if (stb.markFail) begin
        failQ   <= 1'b1;
        resultQ <= '0;
      end
    end
  end
endmodule

// File: rtl/ptw_walker.sv
module ptw_walker
  import ptw_pkg::*;
#(
  parameter int          LEVELS    = 3,
  parameter int          IDX_BITS  = 10,
  parameter int          PG_SHIFT  = 12,
  parameter logic [63:0] MEM_BYTES = 64'h0100_0000
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        start,
  input  logic [63:0] vaddr,
  input  logic [63:0] rootBase,
  input  logic        reqWrite,
  output logic        memRdReq,
  output logic [63:0] memRdAddr,
  input  logic        memRdValid,
  input  logic [63:0] memRdData,
  output logic        memWrReq,
  output logic [63:0] memWrAddr,
  output logic [63:0] memWrData,
  output logic        done,
  output logic        fail,
  output logic [63:0] leafPte
);
  ptwStrobe_t  stb;
  ptwFlags_t   flags;
  logic [63:0] pteAddr;

  ptw_ctrl u_ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .start     (start),
    .memRdValid(memRdValid),
    .flags     (flags),
    .stb       (stb),
    .memRdReq  (memRdReq),
    .memWrReq  (memWrReq),
    .done      (done)
  );

  ptw_datapath #(
    .LEVELS   (LEVELS),
    .IDX_BITS (IDX_BITS),
    .PG_SHIFT (PG_SHIFT),
    .MEM_BYTES(MEM_BYTES)
  ) u_dp (
    .clk      (clk),
    .rstN     (rstN),
    .stb      (stb),
    .vaddr    (vaddr),
    .rootBase (rootBase),
    .reqWrite (reqWrite),
    .memRdData(memRdData),
    .flags    (flags),
    .pteAddr  (pteAddr),
    .wrData   (memWrData),
    .failQ    (fail),
    .resultQ  (leafPte)
  );

  assign memRdAddr = pteAddr;
  assign memWrAddr = pteAddr;
endmodule

// File: rtl/ptw_checker.sv
module ptw_checker #(
  parameter int          PG_SHIFT  = 12,
  parameter logic [63:0] MEM_BYTES = 64'h0100_0000
) (
  input logic        clk,
  input logic        rstN,
  input logic        memRdReq,
  input logic [63:0] memRdAddr,
  input logic        memWrReq,
  input logic [63:0] memWrAddr,
  input logic [63:0] memWrData,
  input logic        done,
  input logic        fail,
  input logic [63:0] leafPte
);
  logic [63:0] lastRdAddr;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)         lastRdAddr <= '0;
    else if (memRdReq) lastRdAddr <= memRdAddr;
  end

  AST_RD_IN_RANGE: assert property (@(posedge clk) disable iff (!rstN)
    memRdReq |-> memRdAddr < MEM_BYTES) else $error("read out of range"); // R3

  AST_RD_ALIGNED: assert property (@(posedge clk) disable iff (!rstN)
    memRdReq |-> memRdAddr[2:0] == 3'b000) else $error("misaligned read"); // R2

  AST_ONE_OUTSTANDING: assert property (@(posedge clk) disable iff (!rstN)
    memRdReq |=> !memRdReq) else $error("back-to-back read"); // R10

  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done) else $error("done longer than one cycle"); // R10

  AST_FAIL_ZERO: assert property (@(posedge clk) disable iff (!rstN)
    (done && fail) |-> leafPte == 64'd0) else $error("failed walk with nonzero leaf"); // R10

  AST_WB_SAME_ADDR: assert property (@(posedge clk) disable iff (!rstN)
    memWrReq |-> (memWrAddr == lastRdAddr && memWrData[8] && memWrData[0])) else $error("bad write-back"); // R6

  AST_LEAF_IN_RANGE: assert property (@(posedge clk) disable iff (!rstN)
    (done && !fail) |-> ({leafPte[63:PG_SHIFT], {PG_SHIFT{1'b0}}} < MEM_BYTES && leafPte[8])) else $error("leaf out of range"); // R8
endmodule

bind ptw_walker ptw_checker #(.PG_SHIFT(PG_SHIFT), .MEM_BYTES(MEM_BYTES)) u_chk (
  .clk(clk), .rstN(rstN), .memRdReq(memRdReq), .memRdAddr(memRdAddr),
  .memWrReq(memWrReq), .memWrAddr(memWrAddr), .memWrData(memWrData),
  .done(done), .fail(fail), .leafPte(leafPte)
);

// File: tb/ptw_walker_tb.sv
module ptw_walker_tb;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        start = 1'b0;
  logic [63:0] vaddr = '0;
  logic [63:0] rootBase = '0;
  logic        reqWrite = 1'b0;
  logic        memRdReq;
  logic [63:0] memRdAddr;
  logic        memRdValid = 1'b0;
  logic [63:0] memRdData = '0;
  logic        memWrReq;
  logic [63:0] memWrAddr;
  logic [63:0] memWrData;
  logic        done;
  logic        fail;
  logic [63:0] leafPte;

  int total = 0;
  int bad = 0;

  logic [63:0] memA [longint unsigned];
  logic        rdPend = 1'b0;
  logic [63:0] rdAddrL = '0;
  logic [63:0] rdLog [8];
  int          rdCnt = 0;
  int          wrCnt = 0;
  logic [63:0] lastWrAddr = '0;
  logic [63:0] lastWrData = '0;

  logic        gotDone, gotFail, doneAfter;
  logic [63:0] gotLeaf;

  always #5 clk = ~clk;

  ptw_walker u_dut (
    .clk(clk), .rstN(rstN), .start(start), .vaddr(vaddr), .rootBase(rootBase),
    .reqWrite(reqWrite), .memRdReq(memRdReq), .memRdAddr(memRdAddr),
    .memRdValid(memRdValid), .memRdData(memRdData), .memWrReq(memWrReq),
    .memWrAddr(memWrAddr), .memWrData(memWrData), .done(done), .fail(fail),
    .leafPte(leafPte)
  );

  // Memory model: two-cycle read latency
  always @(posedge clk) begin
    memRdValid <= rdPend;
    memRdData  <= memA.exists(rdAddrL) ? memA[rdAddrL] : 64'd0;
    rdPend     <= memRdReq;
    rdAddrL    <= memRdAddr;
    if (memRdReq) begin
      if (rdCnt < 8) rdLog[rdCnt] = memRdAddr;
      rdCnt = rdCnt + 1;
    end
    if (memWrReq) begin
      memA[memWrAddr] = memWrData;
      lastWrAddr = memWrAddr;
      lastWrData = memWrData;
      wrCnt = wrCnt + 1;
    end
  end

  task automatic check(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [63:0] mkVa(input int i0, input int i1, input int i2, input int off);
    return (64'(i0) << 32) | (64'(i1) << 22) | (64'(i2) << 12) | 64'(off);
  endfunction

  task automatic runWalk(input logic [63:0] va, input logic [63:0] root, input logic wr);
    int n;
    n = 0;
    @(negedge clk);
    rdCnt = 0;
    wrCnt = 0;
    vaddr = va; rootBase = root; reqWrite = wr; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    while (!done && n < 500) begin
      @(negedge clk);
      n++;
    end
    gotDone = done; gotFail = fail; gotLeaf = leafPte;
    @(negedge clk);
    doneAfter = done;
    check(gotDone == 1'b1, "R10 walk completes", 64'(gotDone), 64'd1);
    check(doneAfter == 1'b0, "R10 done one cycle", 64'(doneAfter), 64'd0);
  endtask

  // Three-level table: root 0x10000 -> 0x11000 -> 0x12000
  task automatic buildChain();
    memA.delete();
    memA[64'h10018] = 64'h11003;
    memA[64'h11028] = 64'h12003;
    memA[64'h12038] = 64'h345005;
  endtask

  task automatic testReset();
    check(done == 1'b0, "R11 done after reset", 64'(done), 64'd0);
    check(memRdReq == 1'b0, "R11 rdreq after reset", 64'(memRdReq), 64'd0);
    check(memWrReq == 1'b0, "R11 wrreq after reset", 64'(memWrReq), 64'd0);
  endtask

  task automatic testFullWalkRead();
    buildChain();
    runWalk(mkVa(3, 5, 7, 'h123), 64'h10000, 1'b0);
    check(gotFail == 1'b0, "R2 full walk ok", 64'(gotFail), 64'd0);
    check(rdCnt == 3, "R2 three reads", 64'(rdCnt), 64'd3);
    check(rdLog[0] == 64'h10018, "R2 top read addr", rdLog[0], 64'h10018);
    check(rdLog[1] == 64'h11028, "R5 mid read addr", rdLog[1], 64'h11028);
    check(rdLog[2] == 64'h12038, "R5 low read addr", rdLog[2], 64'h12038);
    check(gotLeaf == 64'h345105, "R6 leaf ref bit", gotLeaf, 64'h345105);
    check(wrCnt == 1, "R6 one write", 64'(wrCnt), 64'd1);
    check(lastWrAddr == 64'h12038, "R6 write addr", lastWrAddr, 64'h12038);
    check(lastWrData == 64'h345105, "R6 write data", lastWrData, 64'h345105);
  endtask

  task automatic testFullWalkWrite();
    buildChain();
    runWalk(mkVa(3, 5, 7, 0), 64'h10000, 1'b1);
    check(gotLeaf == 64'h345305, "R6 dirty leaf", gotLeaf, 64'h345305);
    check(lastWrData == 64'h345305, "R6 dirty write", lastWrData, 64'h345305);
  endtask

  task automatic testSuperMid();
    buildChain();
    memA[64'h11028] = 64'h400005;
    runWalk(mkVa(3, 5, 7, 0), 64'h10000, 1'b0);
    check(gotFail == 1'b0, "R7 mid superpage ok", 64'(gotFail), 64'd0);
    check(gotLeaf == 64'h407105, "R7 mid superpage fill", gotLeaf, 64'h407105);
    check(lastWrData == 64'h400105, "R7 mid write unfilled", lastWrData, 64'h400105);
    check(rdCnt == 2, "R7 two reads", 64'(rdCnt), 64'd2);
  endtask

  task automatic testSuperTop();
    buildChain();
    memA[64'h10018] = 64'h5;
    runWalk(mkVa(3, 1, 2, 0), 64'h10000, 1'b0);
    check(gotLeaf == 64'h402105, "R7 top superpage fill", gotLeaf, 64'h402105);
  endtask

  task automatic testPhysOob();
    buildChain();
    memA[64'h10018] = 64'h5;
    runWalk(mkVa(3, 5, 7, 0), 64'h10000, 1'b0);
    check(gotFail == 1'b1, "R8 phys oob fails", 64'(gotFail), 64'd1);
    check(gotLeaf == 64'd0, "R8 zero leaf", gotLeaf, 64'd0);
    check(wrCnt == 1, "R8 write-back still done", 64'(wrCnt), 64'd1);
  endtask

  task automatic testInvalid();
    buildChain();
    memA[64'h11028] = 64'h12000;
    runWalk(mkVa(3, 5, 7, 0), 64'h10000, 1'b0);
    check(gotFail == 1'b1, "R4 invalid fails", 64'(gotFail), 64'd1);
    check(gotLeaf == 64'd0, "R4 zero leaf", gotLeaf, 64'd0);
    check(rdCnt == 2, "R4 stops after two reads", 64'(rdCnt), 64'd2);
    check(wrCnt == 0, "R4 no write", 64'(wrCnt), 64'd0);
  endtask

  task automatic testSignExt();
    buildChain();
    runWalk(64'h0000_0200_0000_0000, 64'h10000, 1'b0);
    check(gotFail == 1'b1, "R1 bad sign fails", 64'(gotFail), 64'd1);
    check(rdCnt == 0, "R1 no read", 64'(rdCnt), 64'd0);
    runWalk(64'hFFFF_FE00_0000_0000, 64'h10000, 1'b0);
    check(rdCnt == 1, "R1 good sign walked", 64'(rdCnt), 64'd1);
    check(rdLog[0] == 64'h11000, "R1 negative index addr", rdLog[0], 64'h11000);
  endtask

  task automatic testLastTable();
    buildChain();
    memA[64'h12038] = 64'h13003;
    runWalk(mkVa(3, 5, 7, 0), 64'h10000, 1'b0);
    check(gotFail == 1'b1, "R9 table at bottom fails", 64'(gotFail), 64'd1);
    check(gotLeaf == 64'd0, "R9 zero leaf", gotLeaf, 64'd0);
    check(wrCnt == 0, "R9 no write", 64'(wrCnt), 64'd0);
  endtask

  task automatic testAddrOob();
    memA.delete();
    runWalk(mkVa(3, 0, 0, 0), 64'hFF_FFF8, 1'b0);
    check(gotFail == 1'b1, "R3 entry oob fails", 64'(gotFail), 64'd1);
    check(rdCnt == 0, "R3 no read issued", 64'(rdCnt), 64'd0);
    memA[64'h10018] = 64'hFFF003;
    runWalk(mkVa(3, 'h3FF, 0, 0), 64'h10000, 1'b0);
    check(gotFail == 1'b1, "R3 second-level oob fails", 64'(gotFail), 64'd1);
    check(rdCnt == 1, "R3 only first read", 64'(rdCnt), 64'd1);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    total++;
    bad++;
    $display("FAIL watchdog expired actual=hung expected=finished");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    testReset();
    testFullWalkRead();
    testFullWalkWrite();
    testSuperMid();
    testSuperTop();
    testPhysOob();
    testInvalid();
    testSignExt();
    testLastTable();
    testAddrOob();
    repeat (3) @(negedge clk);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule